// File: doc/BRIEF.md
# Two-State Snooping Coherence Controller

This block is the cache-side controller of one node in a broadcast-snooping coherence scheme that has only two stable block states, idle and modified, and one transient state for a block whose ownership request is in flight. It takes load and store requests from the local processor and snoops exclusive-ownership requests broadcast by other nodes. It accepts data replies from a point-to-point data network. It keeps a per-block state and data array and broadcasts its own ownership requests. It answers other nodes with the block contents and services local accesses that hit.

The storage holds one entry for every block address, so the address is the block index and no block is ever evicted. Every inbound and outbound queue uses a valid/ready handshake. At most one protocol event is taken per cycle, picked in a fixed order: data reply, then snooped request, then local request. An event takes effect only if every outbound queue it must write is ready in that cycle. Otherwise nothing moves, and the event is offered again.

Top module: `mi_snoop_ctrl`

## Requirements
- R1: After reset every block is idle: a local request to any block raises `aout_valid` with no hit.
- R2: A local request to an idle block raises `aout_valid` with `aout_addr` equal to the request address, `aout_type` = 2'b01 (exclusive) and `aout_req_id` = `my_id`. When `aout_ready` is high the block moves to the transient state, and the local request is not popped (`lreq_ready` low).
- R3: A local request to a modified block pops the local queue and pulses `hit_valid` in the same cycle, with `hit_data` holding the block contents from before the access. A store (`lreq_we` = 1) replaces the block with `lreq_wdata`, and the block stays modified.
- R4: A snooped exclusive request (type 2'b01) from another node to a modified block raises `dout_valid` with the snooped address, `dout_dest` = the requestor and the block contents. When `dout_ready` is high the snoop is popped and the block becomes idle.
- R5: A snooped exclusive request from another node to an idle block is popped with no output and no state change.
- R6: A data reply to a block in the transient state is popped, writes its payload into the block and makes it modified. The pending local request then hits on a later cycle.
- R7: While a block is in the transient state, local and snooped requests to it are not popped, and they produce no outbound message.
- R8: A snooped message whose requestor equals `my_id`, or whose type is not 2'b01, is popped with no effect on state, data or outputs.
- R9: An event that needs an outbound queue does nothing while that queue is not ready. Its input is not popped and the block state is unchanged.
- R10: A data reply to an idle or modified block is popped, pulses `proto_err` for that cycle, and leaves state and data unchanged.
- R11: When events are pending on several inbound queues at once, only one is taken, in this order: data reply, then snooped request, then local request. The others are held not ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| my_id | input | ID_W | This node's identifier |
| lreq_valid | input | 1 | Local request present |
| lreq_ready | output | 1 | Local request popped |
| lreq_addr | input | ADDR_W | Local request block address |
| lreq_we | input | 1 | Local request is a store |
| lreq_wdata | input | DATA_W | Store data |
| hit_valid | output | 1 | Local access serviced this cycle |
| hit_data | output | DATA_W | Block contents before the access |
| snp_valid | input | 1 | Snooped address message present |
| snp_ready | output | 1 | Snooped message popped |
| snp_addr | input | ADDR_W | Snooped block address |
| snp_type | input | 2 | Snooped request type |
| snp_req_id | input | ID_W | Snooped requestor |
| din_valid | input | 1 | Data reply present |
| din_ready | output | 1 | Data reply popped |
| din_addr | input | ADDR_W | Data reply block address |
| din_data | input | DATA_W | Data reply payload |
| aout_valid | output | 1 | Outbound ownership request |
| aout_ready | input | 1 | Address network accepts |
| aout_addr | output | ADDR_W | Requested block address |
| aout_type | output | 2 | Request type |
| aout_req_id | output | ID_W | Requestor (this node) |
| dout_valid | output | 1 | Outbound data message |
| dout_ready | input | 1 | Data network accepts |
| dout_addr | output | ADDR_W | Supplied block address |
| dout_dest | output | ID_W | Destination node |
| dout_data | output | DATA_W | Supplied block contents |
| proto_err | output | 1 | Data reply arrived for a block not awaiting it |

## Verification
The filling of a block by a data reply and a snooped request for the same block can arrive in the same cycle. So can a data reply and a local hit, or a snoop and a local hit on a modified block. The bench presents these pairs together on the same edge. It expects the higher-priority queue to be popped alone, with the loser held not ready. In the fill-versus-snoop case it expects the snoop to be answered one cycle later with the freshly written payload. Stalls through a not-ready outbound queue are provoked by holding `aout_ready` or `dout_ready` low for a cycle. The bench then checks that the message stays offered and that nothing was popped.

// File: rtl/mi_snoop_pkg.sv
package mi_snoop_pkg;

  typedef enum logic [1:0] {
    BLK_I  = 2'd0,
    BLK_M  = 2'd1,
    BLK_IM = 2'd2
  } blk_state_t;

  typedef enum logic [1:0] {
    EV_NONE  = 2'd0,
    EV_FILL  = 2'd1,
    EV_SNOOP = 2'd2,
    EV_LOCAL = 2'd3
  } ev_t;

  localparam logic [1:0] REQ_EXCL = 2'b01;

  // A snooped message is acted on only if it is an exclusive request from another node
  function automatic logic snoop_relevant(input logic same_node, input logic [1:0] kind);
    return !same_node && (kind == REQ_EXCL);
  endfunction

  // An event may fire if it needs no outbound queue or the queue it needs is ready
  function automatic logic can_fire(input logic needs_out, input logic out_ready);
    return !needs_out || out_ready;
  endfunction

endpackage

// File: rtl/mi_line_array.sv
module mi_line_array
  import mi_snoop_pkg::*;
#(
  parameter int NBLK   = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx_fill,
  input  logic [IDX_W-1:0]  idx_snp,
  input  logic [IDX_W-1:0]  idx_loc,
  output blk_state_t        st_fill,
  output blk_state_t        st_snp,
  output blk_state_t        st_loc,
  output logic [DATA_W-1:0] dat_snp,
  output logic [DATA_W-1:0] dat_loc,
  input  logic              st_we,
  input  logic [IDX_W-1:0]  st_widx,
  input  blk_state_t        st_wval,
  input  logic              dat_we,
  input  logic [IDX_W-1:0]  dat_widx,
  input  logic [DATA_W-1:0] dat_wval
);

  blk_state_t        st_q  [NBLK];
  logic [DATA_W-1:0] dat_q [NBLK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NBLK; i++) st_q[i] <= BLK_I;
    end else if (st_we) begin
      st_q[st_widx] <= st_wval;
    end
  end

  always_ff @(posedge clk) begin
    if (dat_we) dat_q[dat_widx] <= dat_wval;
  end

  assign st_fill = st_q[idx_fill];
  assign st_snp  = st_q[idx_snp];
  assign st_loc  = st_q[idx_loc];
  assign dat_snp = dat_q[idx_snp];
  assign dat_loc = dat_q[idx_loc];

  // A block only becomes modified together with a data write (fill)
  assert_fill_writes_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_we && st_wval == BLK_M) |-> (dat_we && dat_widx == st_widx));

endmodule

// File: rtl/mi_event_sel.sv
module mi_event_sel
  import mi_snoop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fill_cand,
  input  logic snp_cand,
  input  logic loc_cand,
  input  logic snp_needs_out,
  input  logic loc_needs_out,
  input  logic dout_ready,
  input  logic aout_ready,
  output ev_t  ev,
  output logic ev_fire
);

  always_comb begin
    if (fill_cand)     ev = EV_FILL;
    else if (snp_cand) ev = EV_SNOOP;
    else if (loc_cand) ev = EV_LOCAL;
    else               ev = EV_NONE;
  end

  always_comb begin
    unique case (ev)
      EV_FILL:  ev_fire = 1'b1;
      EV_SNOOP: ev_fire = can_fire(snp_needs_out, dout_ready);
      EV_LOCAL: ev_fire = can_fire(loc_needs_out, aout_ready);
      default:  ev_fire = 1'b0;
    endcase
  end

  // A pending local event never fires while a snoop event is a candidate
  assert_snoop_over_local_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_cand && !fill_cand) |-> (ev == EV_SNOOP));

endmodule

// File: rtl/mi_snoop_ctrl.sv
module mi_snoop_ctrl
  import mi_snoop_pkg::*;
#(
  parameter int NBLK   = 16,
  parameter int DATA_W = 32,
  parameter int ID_W   = 4,
  localparam int ADDR_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   my_id,
  input  logic              lreq_valid,
  output logic              lreq_ready,
  input  logic [ADDR_W-1:0] lreq_addr,
  input  logic              lreq_we,
  input  logic [DATA_W-1:0] lreq_wdata,
  output logic              hit_valid,
  output logic [DATA_W-1:0] hit_data,
  input  logic              snp_valid,
  output logic              snp_ready,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic [1:0]        snp_type,
  input  logic [ID_W-1:0]   snp_req_id,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [ADDR_W-1:0] din_addr,
  input  logic [DATA_W-1:0] din_data,
  output logic              aout_valid,
  input  logic              aout_ready,
  output logic [ADDR_W-1:0] aout_addr,
  output logic [1:0]        aout_type,
  output logic [ID_W-1:0]   aout_req_id,
  output logic              dout_valid,
  input  logic              dout_ready,
  output logic [ADDR_W-1:0] dout_addr,
  output logic [ID_W-1:0]   dout_dest,
  output logic [DATA_W-1:0] dout_data,
  output logic              proto_err
);

  blk_state_t        st_fill, st_snp, st_loc;
  logic [DATA_W-1:0] dat_snp, dat_loc;
  logic              st_we, dat_we;
  logic [ADDR_W-1:0] st_widx, dat_widx;
  blk_state_t        st_wval;
  logic [DATA_W-1:0] dat_wval;

  // Named internal events
  logic snp_ignore, fill_cand, snp_cand, loc_cand;
  logic fire_fill, fire_snp, fire_loc;
  ev_t  ev;
  logic ev_fire;

  assign snp_ignore = snp_valid && !snoop_relevant(snp_req_id == my_id, snp_type);
  assign fill_cand  = din_valid;
  assign snp_cand   = snp_valid && !snp_ignore && (st_snp != BLK_IM);
  assign loc_cand   = lreq_valid && (st_loc != BLK_IM);

  mi_line_array #(.NBLK(NBLK), .DATA_W(DATA_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .idx_fill(din_addr), .idx_snp(snp_addr), .idx_loc(lreq_addr),
    .st_fill(st_fill), .st_snp(st_snp), .st_loc(st_loc),
    .dat_snp(dat_snp), .dat_loc(dat_loc),
    .st_we(st_we), .st_widx(st_widx), .st_wval(st_wval),
    .dat_we(dat_we), .dat_widx(dat_widx), .dat_wval(dat_wval)
  );

  mi_event_sel u_sel (
    .clk(clk), .rst_n(rst_n),
    .fill_cand(fill_cand), .snp_cand(snp_cand), .loc_cand(loc_cand),
    .snp_needs_out(st_snp == BLK_M), .loc_needs_out(st_loc == BLK_I),
    .dout_ready(dout_ready), .aout_ready(aout_ready),
    .ev(ev), .ev_fire(ev_fire)
  );

  assign fire_fill = ev_fire && (ev == EV_FILL);
  assign fire_snp  = ev_fire && (ev == EV_SNOOP);
  assign fire_loc  = ev_fire && (ev == EV_LOCAL);

  // Inbound pops
  assign din_ready  = fire_fill;
  assign snp_ready  = snp_ignore || fire_snp;
  assign lreq_ready = fire_loc && (st_loc == BLK_M);
  assign proto_err  = fire_fill && (st_fill != BLK_IM);

  // Local hit service
  assign hit_valid = lreq_ready;
  assign hit_data  = dat_loc;

  // Outbound ownership request
  assign aout_valid  = (ev == EV_LOCAL) && (st_loc == BLK_I);
  assign aout_addr   = lreq_addr;
  assign aout_type   = REQ_EXCL;
  assign aout_req_id = my_id;

  // Outbound data supply
  assign dout_valid = (ev == EV_SNOOP) && (st_snp == BLK_M);
  assign dout_addr  = snp_addr;
  assign dout_dest  = snp_req_id;
  assign dout_data  = dat_snp;

  // State and data updates: at most one event per cycle
  always_comb begin
    st_we    = 1'b0;
    st_widx  = '0;
    st_wval  = BLK_I;
    dat_we   = 1'b0;
    dat_widx = '0;
    dat_wval = '0;
    if (fire_fill && st_fill == BLK_IM) begin
      st_we = 1'b1;  st_widx = din_addr;  st_wval = BLK_M;
      dat_we = 1'b1; dat_widx = din_addr; dat_wval = din_data;
    end else if (fire_snp && st_snp == BLK_M) begin
      st_we = 1'b1;  st_widx = snp_addr;  st_wval = BLK_I;
    end else if (fire_loc && st_loc == BLK_I) begin
      st_we = 1'b1;  st_widx = lreq_addr; st_wval = BLK_IM;
    end else if (fire_loc && st_loc == BLK_M && lreq_we) begin
      dat_we = 1'b1; dat_widx = lreq_addr; dat_wval = lreq_wdata;
    end
  end

  assert_issue_keeps_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    aout_valid |-> !lreq_ready);

  assert_transient_no_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && st_snp == BLK_IM) |-> !dout_valid);

  assert_no_self_reply_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> (dout_dest != my_id));

  assert_atomic_supply_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_valid && !dout_ready) |-> !snp_ready);

  assert_err_pops_reply_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (din_valid && din_ready));

  assert_local_yields_R11: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_ready |-> !din_valid);

endmodule

// File: tb/mi_snoop_ctrl_test.sv
module mi_snoop_ctrl_test;
  localparam int CLK_P = 10;
  localparam logic [3:0] MY = 4'd5;
  localparam logic [3:0] OTHER = 4'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] my_id = MY;
  logic lreq_valid = 0, lreq_ready, lreq_we = 0;
  logic [3:0] lreq_addr = 0;
  logic [31:0] lreq_wdata = 0;
  logic hit_valid;
  logic [31:0] hit_data;
  logic snp_valid = 0, snp_ready;
  logic [3:0] snp_addr = 0, snp_req_id = 0;
  logic [1:0] snp_type = 0;
  logic din_valid = 0, din_ready;
  logic [3:0] din_addr = 0;
  logic [31:0] din_data = 0;
  logic aout_valid, aout_ready = 0;
  logic [3:0] aout_addr, aout_req_id;
  logic [1:0] aout_type;
  logic dout_valid, dout_ready = 0;
  logic [3:0] dout_addr, dout_dest;
  logic [31:0] dout_data;
  logic proto_err;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  mi_snoop_ctrl uut (
    .clk(clk), .rst_n(rst_n), .my_id(my_id),
    .lreq_valid(lreq_valid), .lreq_ready(lreq_ready), .lreq_addr(lreq_addr),
    .lreq_we(lreq_we), .lreq_wdata(lreq_wdata),
    .hit_valid(hit_valid), .hit_data(hit_data),
    .snp_valid(snp_valid), .snp_ready(snp_ready), .snp_addr(snp_addr),
    .snp_type(snp_type), .snp_req_id(snp_req_id),
    .din_valid(din_valid), .din_ready(din_ready), .din_addr(din_addr), .din_data(din_data),
    .aout_valid(aout_valid), .aout_ready(aout_ready), .aout_addr(aout_addr),
    .aout_type(aout_type), .aout_req_id(aout_req_id),
    .dout_valid(dout_valid), .dout_ready(dout_ready), .dout_addr(dout_addr),
    .dout_dest(dout_dest), .dout_data(dout_data), .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Drive on the falling edge, check settled outputs 1 time unit later
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic quiet();
    lreq_valid = 0; lreq_we = 0; snp_valid = 0; din_valid = 0;
    aout_ready = 0; dout_ready = 0;
  endtask

  task automatic snoop(input logic [3:0] a, input logic [3:0] id, input logic [1:0] t);
    snp_valid = 1; snp_addr = a; snp_req_id = id; snp_type = t;
  endtask

  task automatic bring_to_m(input logic [3:0] a, input logic [31:0] d);
    step(); quiet(); lreq_valid = 1; lreq_addr = a; aout_ready = 1;
    step(); quiet(); din_valid = 1; din_addr = a; din_data = d;
    step(); quiet();
  endtask

  task automatic t_reset_issue();
    step(); quiet(); lreq_valid = 1; lreq_addr = 4'd3; settle();
    chk("R1 aout_valid after reset", aout_valid, 1);
    chk("R2 aout_addr", aout_addr, 3);
    chk("R2 aout_type", aout_type, 2'b01);
    chk("R2 aout_req_id", aout_req_id, MY);
    chk("R1 no hit", hit_valid, 0);
    step(); settle();
    chk("R9 request held while address queue full", aout_valid, 1);
    chk("R9 local not popped", lreq_ready, 0);
    step(); aout_ready = 1; settle();
    chk("R2 local not popped on issue", lreq_ready, 0);
    step(); aout_ready = 0; snoop(4'd3, OTHER, 2'b01); settle();
    chk("R7 local stalled in transient", lreq_ready | aout_valid, 0);
    chk("R7 snoop stalled in transient", snp_ready | dout_valid, 0);
  endtask

  task automatic t_fill_and_hit();
    step(); snp_valid = 0; din_valid = 1; din_addr = 4'd3; din_data = 32'hA5A5A5A5; settle();
    chk("R6 fill popped", din_ready, 1);
    chk("R6 no error on fill", proto_err, 0);
    step(); din_valid = 0; lreq_we = 1; lreq_wdata = 32'h12345678; settle();
    chk("R6 pending request hits", hit_valid, 1);
    chk("R3 hit data is filled payload", hit_data, 32'hA5A5A5A5);
    chk("R3 local popped on hit", lreq_ready, 1);
    step(); lreq_we = 0; settle();
    chk("R3 store updated block", hit_data, 32'h12345678);
    step(); quiet();
  endtask

  task automatic t_snoop_m();
    snoop(4'd3, OTHER, 2'b01); settle();
    chk("R9 supply offered", dout_valid, 1);
    chk("R9 snoop held while data queue full", snp_ready, 0);
    step(); dout_ready = 1; settle();
    chk("R4 dout_data", dout_data, 32'h12345678);
    chk("R4 dout_dest", dout_dest, OTHER);
    chk("R4 dout_addr", dout_addr, 3);
    chk("R4 snoop popped", snp_ready, 1);
    step(); quiet(); lreq_valid = 1; lreq_addr = 4'd3; settle();
    chk("R4 block now idle", aout_valid, 1);
    step(); quiet();
  endtask

  task automatic t_snoop_i();
    snoop(4'd7, OTHER, 2'b01); settle();
    chk("R5 snoop on idle popped", snp_ready, 1);
    chk("R5 no supply", dout_valid, 0);
    step(); quiet(); lreq_valid = 1; lreq_addr = 4'd7; settle();
    chk("R5 block still idle", aout_valid, 1);
    step(); quiet();
  endtask

  task automatic t_ignore();
    bring_to_m(4'd9, 32'h55);
    snoop(4'd9, MY, 2'b01); dout_ready = 1; settle();
    chk("R8 own request popped", snp_ready, 1);
    chk("R8 own request no supply", dout_valid, 0);
    step(); snoop(4'd9, OTHER, 2'b10); settle();
    chk("R8 other type popped", snp_ready, 1);
    chk("R8 other type no supply", dout_valid, 0);
    step(); quiet(); lreq_valid = 1; lreq_addr = 4'd9; settle();
    chk("R8 block still modified", hit_valid, 1);
    chk("R8 data unchanged", hit_data, 32'h55);
    step(); quiet();
  endtask

  task automatic t_priority_err();
    din_valid = 1; din_addr = 4'd4; din_data = 32'h99; lreq_valid = 1; lreq_addr = 4'd9; settle();
    chk("R10 error reply popped", din_ready, 1);
    chk("R10 proto_err on idle block", proto_err, 1);
    chk("R11 local held behind data", lreq_ready, 0);
    step(); din_valid = 0; settle();
    chk("R10 proto_err one cycle", proto_err, 0);
    chk("R11 local served next", hit_data, 32'h55);
    step(); lreq_addr = 4'd4; settle();
    chk("R10 idle block unchanged", aout_valid, 1);
    step(); quiet(); din_valid = 1; din_addr = 4'd9; din_data = 32'h99; settle();
    chk("R10 proto_err on modified block", proto_err, 1);
    step(); din_valid = 0; lreq_valid = 1; lreq_addr = 4'd9; settle();
    chk("R10 modified data unchanged", hit_data, 32'h55);
    step(); snoop(4'd9, OTHER, 2'b01); dout_ready = 1; settle();
    chk("R11 snoop beats local", snp_ready, 1);
    chk("R11 local held behind snoop", lreq_ready, 0);
    step(); quiet();
  endtask

  task automatic t_fill_snoop_race();
    lreq_valid = 1; lreq_addr = 4'd12; aout_ready = 1;
    step(); quiet(); din_valid = 1; din_addr = 4'd12; din_data = 32'h77;
    snoop(4'd12, OTHER, 2'b01); dout_ready = 1; settle();
    chk("R11 fill taken first", din_ready, 1);
    chk("R11 snoop held behind fill", snp_ready, 0);
    step(); din_valid = 0; settle();
    chk("R6 snoop answered after fill", dout_valid, 1);
    chk("R6 supplied fresh payload", dout_data, 32'h77);
    step(); quiet();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset_issue();
    t_fill_and_hit();
    t_snoop_m();
    t_snoop_i();
    t_ignore();
    t_priority_err();
    t_fill_snoop_race();
    finish_run();
  end
endmodule